// File: doc/BRIEF.md
# Dual-Channel Serial Converter Code Front-End

This block is the digital control section in front of a two-channel 12-bit converter. A serial word arrives on a data pin and is clocked into a shift register by an external serial clock, but only while the active-low chip select is asserted. Two channel code registers, A and B, then take the shift register contents through their own active-low load strobes. These strobes are level-sensitive: a channel register follows the shift register for as long as its strobe is low.

An active-low clear pin forces both channel codes to a preset value. A selector pin chooses the preset: mid-scale or zero. The clear has priority over the strobes. A shutdown pin is passed through as a flag and leaves every register as it is. Every pin is oversampled by a fast system clock through two-flop synchronizers, so the whole block runs in that single clock domain. A sticky flag reports a serial clock edge that was taken while a strobe was low.

Top module: `sdac_front`

## Requirements
- R1: On each synchronized rising edge of `sclk_i`, one bit of `sdata_i` is shifted in, but only while `csel_n_i` is low. With `csel_n_i` high, serial clock edges leave the shift register unchanged.
- R2: Bits enter most significant first. After more than CODE_W (12) bits, the shift register holds the last 12 bits clocked in, with the last bit at bit 0.
- R3: While `ld_a_n_i` (or `ld_b_n_i`) is low, `code_a_o` (or `code_b_o`) follows the shift register. While the strobe is high, the code holds its value.
- R4: The load strobes work the same whatever the level of `csel_n_i`.
- R5: While `clr_n_i` is low, both codes are forced to 12'h800 if `mid_sel_i` is high, and to 12'h000 if `mid_sel_i` is low.
- R6: The clear overrides both strobes. A strobe that is still low when `clr_n_i` rises makes its channel take the shift register contents.
- R7: `sleep_n_i` low sets `sleep_o` high and changes no register. Serial data and strobes are still accepted while it is low.
- R8: `seq_err_o` goes high after an accepted serial clock edge while either strobe is low. It stays high until `clr_n_i` is driven low, which clears it.
- R9: After the system reset `rst_n_i`, the shift register, both codes and `seq_err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oversampling clock |
| rst_n_i | input | 1 | Power-up reset, active low |
| sclk_i | input | 1 | Serial clock pin |
| sdata_i | input | 1 | Serial data pin |
| csel_n_i | input | 1 | Chip select, active low |
| ld_a_n_i | input | 1 | Channel A load strobe, active low, level-sensitive |
| ld_b_n_i | input | 1 | Channel B load strobe, active low, level-sensitive |
| clr_n_i | input | 1 | Preset clear of both channels, active low |
| mid_sel_i | input | 1 | Preset select: 1 gives mid-scale, 0 gives zero |
| sleep_n_i | input | 1 | Shutdown request, active low |
| code_a_o | output | 12 | Channel A code |
| code_b_o | output | 12 | Channel B code |
| sleep_o | output | 1 | Shutdown flag |
| seq_err_o | output | 1 | Sticky flag: serial clock edge taken while a strobe was low |

## Verification
Words of exactly 12 bits show that the bit order is correct. Longer words of 13 to 16 bits show that only the trailing 12 bits are kept. Words sent with chip select high show that edges are gated, because a later load must return the older contents. Clear pulses are applied under both selector levels, and once with a strobe held low through the release, to tell preset priority apart from strobe transparency. A write made during shutdown, and a shift made with a strobe held low, check the shutdown pass-through and the error flag.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
   localparam int unsigned NUM_CH   = 2;
   localparam int unsigned NUM_PINS = 8;

   // positions of the pins inside the synchronizer vector
   typedef enum int unsigned {
      PIN_SCLK  = 0,
      PIN_SDATA = 1,
      PIN_CSEL  = 2,
      PIN_LDA   = 3,
      PIN_LDB   = 4,
      PIN_CLR   = 5,
      PIN_MID   = 6,
      PIN_SLEEP = 7
   } pin_idx_e;

   // idle levels: active-low controls rest high
   localparam logic [NUM_PINS-1:0] PIN_IDLE = 8'hBC;
endpackage

// File: rtl/sdac_pin_sync.sv
module sdac_pin_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] IDLE = '0
) (
   input  logic             clk_i,
   input  logic             rst_n_i,
   input  logic [WIDTH-1:0] pin_i,
   output logic [WIDTH-1:0] sync_o
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) stage_q[s] <= IDLE;
            else          stage_q[s] <= pin_i;
         end
      end else begin : g_next
         always_ff @(posedge clk_i or negedge rst_n_i) begin
            if (!rst_n_i) stage_q[s] <= IDLE;
            else          stage_q[s] <= stage_q[s-1];
         end
      end
   end

   assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              step_i,
   input  logic              bit_i,
   output logic [CODE_W-1:0] word_o
);
   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)    word_o <= '0;
      else if (step_i) word_o <= {word_o[CODE_W-2:0], bit_i};
   end
endmodule

// File: rtl/sdac_chan_reg.sv
module sdac_chan_reg #(
   parameter int unsigned CODE_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              clr_i,
   input  logic              mid_i,
   input  logic              follow_i,
   input  logic [CODE_W-1:0] src_i,
   output logic [CODE_W-1:0] code_o
);
   localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] code_d;

   always_comb begin
      if (clr_i)         code_d = mid_i ? MID_CODE : '0;
      else if (follow_i) code_d = src_i;
      else               code_d = code_o;
   end

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) code_o <= '0;
      else          code_o <= code_d;
   end
endmodule

// File: rtl/sdac_front.sv
module sdac_front #(
   parameter int unsigned CODE_W      = 12,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk_i,
   input  logic              rst_n_i,
   input  logic              sclk_i,
   input  logic              sdata_i,
   input  logic              csel_n_i,
   input  logic              ld_a_n_i,
   input  logic              ld_b_n_i,
   input  logic              clr_n_i,
   input  logic              mid_sel_i,
   input  logic              sleep_n_i,
   output logic [CODE_W-1:0] code_a_o,
   output logic [CODE_W-1:0] code_b_o,
   output logic              sleep_o,
   output logic              seq_err_o
);
   import sdac_pkg::*;

   initial begin
      assert (CODE_W >= 2) else $error("CODE_W must be at least 2");
      assert (SYNC_STAGES >= 2) else $error("SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pin_raw, pin_s;
   logic                sclk_d;
   logic                shift_en;
   logic                csel_n_s, clr_act, mid_s;
   logic [NUM_CH-1:0]   ld_n_s;
   logic [CODE_W-1:0]   shift_word;
   logic [CODE_W-1:0]   codes [NUM_CH];

   assign pin_raw[PIN_SCLK]  = sclk_i;
   assign pin_raw[PIN_SDATA] = sdata_i;
   assign pin_raw[PIN_CSEL]  = csel_n_i;
   assign pin_raw[PIN_LDA]   = ld_a_n_i;
   assign pin_raw[PIN_LDB]   = ld_b_n_i;
   assign pin_raw[PIN_CLR]   = clr_n_i;
   assign pin_raw[PIN_MID]   = mid_sel_i;
   assign pin_raw[PIN_SLEEP] = sleep_n_i;

   sdac_pin_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES),
      .IDLE   (PIN_IDLE)
   ) i_sync (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .pin_i   (pin_raw),
      .sync_o  (pin_s)
   );

   assign csel_n_s  = pin_s[PIN_CSEL];
   assign clr_act   = !pin_s[PIN_CLR];
   assign mid_s     = pin_s[PIN_MID];
   assign ld_n_s[0] = pin_s[PIN_LDA];
   assign ld_n_s[1] = pin_s[PIN_LDB];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i) sclk_d <= 1'b0;
      else          sclk_d <= pin_s[PIN_SCLK];
   end

   assign shift_en = pin_s[PIN_SCLK] && !sclk_d && !csel_n_s;

   sdac_shifter #(.CODE_W(CODE_W)) i_shift (
      .clk_i   (clk_i),
      .rst_n_i (rst_n_i),
      .step_i  (shift_en),
      .bit_i   (pin_s[PIN_SDATA]),
      .word_o  (shift_word)
   );

   for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
      sdac_chan_reg #(.CODE_W(CODE_W)) i_chan (
         .clk_i    (clk_i),
         .rst_n_i  (rst_n_i),
         .clr_i    (clr_act),
         .mid_i    (mid_s),
         .follow_i (!ld_n_s[c]),
         .src_i    (shift_word),
         .code_o   (codes[c])
      );
   end

   assign code_a_o = codes[0];
   assign code_b_o = codes[1];
   assign sleep_o  = !pin_s[PIN_SLEEP];

   always_ff @(posedge clk_i or negedge rst_n_i) begin
      if (!rst_n_i)                      seq_err_o <= 1'b0;
      else if (clr_act)                  seq_err_o <= 1'b0;
      else if (shift_en && !(&ld_n_s))   seq_err_o <= 1'b1;
   end
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
   parameter int unsigned CODE_W = 12
) (
   input logic              clk_i,
   input logic              rst_n_i,
   input logic              csel_n_s,
   input logic              clr_act,
   input logic              mid_s,
   input logic [1:0]        ld_n_s,
   input logic              shift_en,
   input logic [CODE_W-1:0] shift_word,
   input logic [CODE_W-1:0] code_a_o,
   input logic [CODE_W-1:0] code_b_o,
   input logic              seq_err_o
);
   localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

   p_cs_gate_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      csel_n_s |=> $stable(shift_word));

   p_follow_a_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!clr_act && !ld_n_s[0]) |=> code_a_o == $past(shift_word));

   p_hold_b_r3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (!clr_act && ld_n_s[1]) |=> $stable(code_b_o));

   p_preset_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      clr_act |=> (code_a_o == ($past(mid_s) ? MID_CODE : '0))
               && (code_b_o == code_a_o));

   p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      (shift_en && !(&ld_n_s) && !clr_act) |=> seq_err_o);

   p_err_clr_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
      clr_act |=> !seq_err_o);
endmodule

bind sdac_front sdac_front_chk #(.CODE_W(CODE_W)) i_chk (
   .clk_i      (clk_i),
   .rst_n_i    (rst_n_i),
   .csel_n_s   (csel_n_s),
   .clr_act    (clr_act),
   .mid_s      (mid_s),
   .ld_n_s     (ld_n_s),
   .shift_en   (shift_en),
   .shift_word (shift_word),
   .code_a_o   (code_a_o),
   .code_b_o   (code_b_o),
   .seq_err_o  (seq_err_o)
);

// File: tb/test_sdac_front.sv
module test_sdac_front;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sclk = 1'b0, sdata = 1'b0, csel_n = 1'b1;
   logic        ld_a_n = 1'b1, ld_b_n = 1'b1, clr_n = 1'b1;
   logic        mid_sel = 1'b0, sleep_n = 1'b1;
   logic [11:0] code_a, code_b;
   logic        sleep_f, err_f;

   logic [11:0] exp_sh = '0, exp_a = '0, exp_b = '0;
   logic        exp_err = 1'b0;
   int          checks = 0, errors = 0;

   always #2 clk = ~clk;

   sdac_front i_sdac_front (
      .clk_i(clk), .rst_n_i(rst_n), .sclk_i(sclk), .sdata_i(sdata),
      .csel_n_i(csel_n), .ld_a_n_i(ld_a_n), .ld_b_n_i(ld_b_n),
      .clr_n_i(clr_n), .mid_sel_i(mid_sel), .sleep_n_i(sleep_n),
      .code_a_o(code_a), .code_b_o(code_b), .sleep_o(sleep_f),
      .seq_err_o(err_f)
   );

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string tag, input logic [11:0] act, input logic [11:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      check({tag, " code_a"}, code_a, exp_a);
      check({tag, " code_b"}, code_b, exp_b);
      check({tag, " seq_err"}, {11'd0, err_f}, {11'd0, exp_err});
   endtask

   // model of one serial word, MSB first
   task automatic send_bits(input logic [31:0] val, input int n, input logic cs_n);
      csel_n = cs_n;
      wait_clk(3);
      for (int i = n - 1; i >= 0; i--) begin
         sdata = val[i];
         wait_clk(3);
         sclk = 1'b1;
         wait_clk(4);
         sclk = 1'b0;
         wait_clk(3);
         if (!cs_n) begin
            exp_sh = {exp_sh[10:0], val[i]};
            if (!ld_a_n || !ld_b_n) exp_err = 1'b1;
            if (!ld_a_n) exp_a = exp_sh;
            if (!ld_b_n) exp_b = exp_sh;
         end
      end
      csel_n = 1'b1;
      wait_clk(3);
   endtask

   task automatic load(input int ch);
      if (ch == 0) ld_a_n = 1'b0; else ld_b_n = 1'b0;
      wait_clk(6);
      if (ch == 0) exp_a = exp_sh; else exp_b = exp_sh;
      if (ch == 0) ld_a_n = 1'b1; else ld_b_n = 1'b1;
      wait_clk(6);
   endtask

   function automatic logic [11:0] preset(input logic m);
      return m ? 12'h800 : 12'h000;
   endfunction

   task automatic clear_pulse(input string tag);
      clr_n = 1'b0;
      wait_clk(6);
      exp_a = preset(mid_sel);
      exp_b = preset(mid_sel);
      exp_err = 1'b0;
      check_all(tag);
      clr_n = 1'b1;
      wait_clk(6);
      if (!ld_a_n) exp_a = exp_sh;
      if (!ld_b_n) exp_b = exp_sh;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      wait_clk(5);
      rst_n = 1'b1;
      wait_clk(5);
      check_all("R9 reset");

      // R1 R2: exact word, held until load (R3 hold)
      send_bits(32'hA5C, 12, 1'b0);
      check_all("R3 hold before load");
      load(0);
      check_all("R1 R2 load A");

      // R2: overlong word keeps trailing bits
      send_bits(32'hF123, 16, 1'b0);
      load(1);
      check("R2 trailing 12 bits", code_b, 12'h123);
      check_all("R2 overlong");

      // R1: chip select high ignores edges; R4 load with csel high
      send_bits(32'h777, 12, 1'b1);
      load(0);
      check("R1 gated shift", code_a, 12'h123);
      check_all("R4 strobe with csel high");

      // R5 both preset levels
      mid_sel = 1'b1; wait_clk(4);
      clear_pulse("R5 mid-scale");
      check_all("R5 after mid release");
      mid_sel = 1'b0; wait_clk(4);
      clear_pulse("R5 zero");
      check_all("R5 after zero release");

      // R6 strobe held through clear release
      send_bits(32'h5A6, 12, 1'b0);
      ld_b_n = 1'b0; wait_clk(6);
      exp_b = exp_sh;
      clear_pulse("R6 clear beats strobe");
      check_all("R6 release with strobe low");
      ld_b_n = 1'b1; wait_clk(6);

      // R7 shutdown
      sleep_n = 1'b0; wait_clk(5);
      check("R7 sleep flag", {11'd0, sleep_f}, 12'd1);
      check_all("R7 regs kept in shutdown");
      send_bits(32'h3E1, 12, 1'b0);
      load(0);
      check_all("R7 write during shutdown");
      sleep_n = 1'b1; wait_clk(5);
      check("R7 sleep flag off", {11'd0, sleep_f}, 12'd0);
      check_all("R7 after shutdown");

      // R8 shift with strobe low
      ld_a_n = 1'b0; wait_clk(6);
      exp_a = exp_sh;
      send_bits(32'h0F0, 12, 1'b0);
      ld_a_n = 1'b1; wait_clk(6);
      check("R8 error flag set", {11'd0, err_f}, 12'd1);
      check_all("R8 transparent during shift");
      send_bits(32'h111, 12, 1'b0);
      check("R8 error flag sticky", {11'd0, err_f}, 12'd1);
      clear_pulse("R8 clear resets flag");
      check_all("R8 after clear");

      // randomized mix
      for (int it = 0; it < 20; it++) begin
         logic [31:0] v;
         int          nb, ch;
         logic        cs;
         v  = $urandom;
         nb = 12 + int'($urandom_range(4));
         cs = ($urandom_range(3) == 0);
         ch = int'($urandom_range(2));
         send_bits(v, nb, cs);
         if (ch < 2) load(ch);
         check_all("R2 random word");
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule